// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a bus target for a two-wire serial management bus. It holds a small bank of 8-bit configuration registers plus one byte-count register, and serves indexed block transfers. Each transfer names a starting register index and, for writes, a byte count. The clock and data lines are synchronised into a faster system clock. The block pulls the data line low through an open-drain enable and never drives it high.

A host writes by sending the write address, an index N, a count X and X data bytes. For a read, the host sends the write address and index N, then a repeated start and the read address. The target then returns the count register first, followed by the registers from N upward, until the host refuses a byte. All register contents are visible on a flat parallel output for use elsewhere on the chip.

Top module: `smbus_blk_regs`

## Requirements
- R1: The address byte 0xDC (write) or 0xDD (read) is acknowledged. The 7-bit address 0x6E sits in bits 7:1 and the direction flag in bit 0. Any other address is not acknowledged, and all following bytes are ignored and not acknowledged until the next start.
- R2: In a block write, the index byte, the count byte and each of the X data bytes are acknowledged. Data byte k (starting at 0) is stored in register N+k.
- R3: Data bytes sent after the X counted bytes are not acknowledged and change no register.
- R4: After a read address, the target first sends the count register value, then registers N, N+1, … in increasing order, MSB first.
- R5: When the host does not acknowledge a byte sent by the target, the target releases the data line and stays released until the next start.
- R6: A stop seen at any point ends the current transfer. A partly received byte is discarded. The next start begins address reception again.
- R7: Index NREGS (8 by default) is the count register, which can be read and written. Indices above it read back as 0x00 and ignore writes.
- R8: After reset all bank registers are 0x00, the count register equals NREGS, and the data line is released.
- R9: The data-line enable changes only while the clock line is low, except for the release that follows a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| regs_o | output | NREGS*8 | Bank registers, register i at bits 8i+7:8i |
| cnt_o | output | 8 | Count register value |

## Verification
The bench sends block writes of different lengths and start indices. These separate correct ascending placement from an off-by-one in the pointer. A write that sends more bytes than its count shows whether the count limits storage and acknowledgement. Reads at the start of the bank and across its end show three sources in one stream: the count byte, bank data and the count register at its index, followed by zero fill. Transfers with a wrong address or an early stop, followed by a normal transfer, show that the target ignores foreign traffic and can start again cleanly.

// File: rtl/smbus_blk_regs.sv
`timescale 1ns/1ps
module smbus_blk_regs #(
  parameter int NREGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h6E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] regs_o,
  output logic [7:0]         cnt_o
);
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [7:0] LAST  = 8'(NREGS - 1);
  localparam logic [7:0] CNTIX = 8'(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_CNT, S_WDAT, S_RACK, S_RCNT, S_RDAT} st_t;

  logic [2:0] scl_q, sda_q;
  logic       scl_s, scl_p, sda_s, rise, fall, sta, stp;
  st_t        st;
  logic [7:0] mem [NREGS];
  logic [7:0] cnt_r, ptr, left, sh, rd_byte;
  logic [3:0] bitn;
  logic       ackph, hack, oe, rx, tx;

  assign scl_s = scl_q[1];
  assign scl_p = scl_q[2];
  assign sda_s = sda_q[1];
  assign rise  = scl_s & ~scl_p;
  assign fall  = ~scl_s & scl_p;
  assign sta   = scl_s & scl_p & sda_q[2] & ~sda_q[1];
  assign stp   = scl_s & scl_p & ~sda_q[2] & sda_q[1];
  assign rx    = st inside {S_ADDR, S_IDX, S_CNT, S_WDAT};
  assign tx    = st inside {S_RCNT, S_RDAT};
  assign sda_oe = oe;
  assign cnt_o  = cnt_r;

  for (genvar i = 0; i < NREGS; i++) begin : g_out
    assign regs_o[i*8 +: 8] = mem[i];
  end

  always_comb begin
    rd_byte = 8'h00;
    if (ptr <= LAST) rd_byte = mem[ptr[AW-1:0]];
    else if (ptr == CNTIX) rd_byte = cnt_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; oe <= 1'b0; ackph <= 1'b0; hack <= 1'b0;
      bitn <= '0; sh <= '0; ptr <= '0; left <= '0; cnt_r <= CNTIX;
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (sta) begin
      st <= S_ADDR; bitn <= '0; ackph <= 1'b0; oe <= 1'b0;
    end else if (stp) begin
      st <= S_IDLE; ackph <= 1'b0; oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (rise) begin
        if (!ackph) begin
          bitn <= bitn + 4'd1;
          if (rx) sh <= {sh[6:0], sda_s};
        end else begin
          hack <= ~sda_s;
        end
      end
      if (fall) begin
        if (!ackph && bitn == 4'd8) begin
          ackph <= 1'b1;
          oe <= 1'b0;
          case (st)
            S_ADDR:
              if (sh[7:1] == DEV_ADDR) begin
                oe <= 1'b1;
                st <= sh[0] ? S_RACK : S_IDX;
              end else begin
                st <= S_IDLE; ackph <= 1'b0;
              end
            S_IDX: begin ptr <= sh; oe <= 1'b1; st <= S_CNT; end
            S_CNT: begin left <= sh; oe <= 1'b1; st <= S_WDAT; end
            S_WDAT:
              if (left != 8'd0) begin
                if (ptr <= LAST) mem[ptr[AW-1:0]] <= sh;
                else if (ptr == CNTIX) cnt_r <= sh;
                ptr <= ptr + 8'd1;
                left <= left - 8'd1;
                oe <= 1'b1;
              end else begin
                st <= S_IDLE; ackph <= 1'b0;
              end
            default: ;
          endcase
        end else if (ackph) begin
          ackph <= 1'b0; bitn <= '0; oe <= 1'b0;
          if (st == S_RACK) begin
            st <= S_RCNT; sh <= cnt_r; oe <= ~cnt_r[7];
          end else if (tx) begin
            if (hack) begin
              st <= S_RDAT; sh <= rd_byte; oe <= ~rd_byte[7]; ptr <= ptr + 8'd1;
            end else begin
              st <= S_IDLE;
            end
          end
        end else if (tx) begin
          oe <= ~sh[6];
          sh <= {sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/smbus_blk_regs_chk.sv
`timescale 1ns/1ps
module smbus_blk_regs_chk #(
  parameter int NREGS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_in,
  input logic               sda_oe,
  input logic [NREGS*8-1:0] regs_o,
  input logic [2:0]         st,
  input logic               sta,
  input logic               stp
);
  a_r9_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(sta) && !$past(stp)) |-> !scl_in);

  a_r2_write_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !scl_in);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  a_r6_stop_returns: assert property (@(posedge clk) disable iff (!rst_n)
    stp |=> (st == 3'd0 && !sda_oe));
endmodule

bind smbus_blk_regs smbus_blk_regs_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .regs_o(regs_o), .st(st), .sta(sta), .stp(stp)
);

// File: tb/smbus_blk_regs_bench.sv
`timescale 1ns/1ps
module smbus_blk_regs_bench;
  localparam int NREGS = 8;
  localparam int Q = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [NREGS*8-1:0] regs_o;
  logic [7:0] cnt_o;
  logic sda_line;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  assign sda_line = sda_h & ~sda_oe;

  always #4 clk = ~clk;

  smbus_blk_regs #(.NREGS(NREGS)) u_smbus_blk_regs (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o), .cnt_o(cnt_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic bus_start();
    sda_h = 1'b1; #Q scl = 1'b1; #Q sda_h = 1'b0; #Q scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; #Q scl = 1'b1; #Q sda_h = 1'b1; #Q;
  endtask

  task automatic bit_w(input logic v);
    sda_h = v; #Q scl = 1'b1; #(2*Q) scl = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    sda_h = 1'b1; #Q scl = 1'b1; #Q ack = ~sda_line; #Q scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q scl = 1'b1; #Q b[i] = sda_line; #Q scl = 1'b0; #Q;
    end
    bit_w(~ack);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREGS; i++) chk(rg(i) == 8'h00, "R8 bank reset", rg(i), 0);
    chk(cnt_o == 8'(NREGS), "R8 count reset", cnt_o, NREGS);
    chk(sda_oe == 1'b0, "R8 line released", sda_oe, 0);
  endtask

  task automatic t_block_write();
    bit a;
    bus_start();
    send_byte(8'hDC, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'h02, a); chk(a, "R2 index ack", a, 1);
    send_byte(8'h03, a); chk(a, "R2 count ack", a, 1);
    send_byte(8'hA1, a); chk(a, "R2 data ack", a, 1);
    send_byte(8'hA2, a); chk(a, "R2 data ack", a, 1);
    send_byte(8'hA3, a); chk(a, "R2 data ack", a, 1);
    bus_stop();
    chk(rg(2) == 8'hA1, "R2 reg2", rg(2), 8'hA1);
    chk(rg(3) == 8'hA2, "R2 reg3", rg(3), 8'hA2);
    chk(rg(4) == 8'hA3, "R2 reg4", rg(4), 8'hA3);
    chk(rg(1) == 8'h00 && rg(5) == 8'h00, "R2 neighbours", {rg(1), rg(5)}, 0);
  endtask

  task automatic t_overrun();
    bit a;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'h06, a);
    send_byte(8'h01, a);
    send_byte(8'h55, a); chk(a, "R3 counted byte ack", a, 1);
    send_byte(8'h66, a); chk(!a, "R3 extra byte nack", a, 0);
    bus_stop();
    chk(rg(6) == 8'h55, "R3 reg6", rg(6), 8'h55);
    chk(rg(7) == 8'h00, "R3 reg7 untouched", rg(7), 0);
  endtask

  task automatic t_block_read();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(8'hDD, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(b, 1'b1); chk(b == 8'(NREGS), "R4 count first", b, NREGS);
    recv_byte(b, 1'b1); chk(b == 8'hA1, "R4 data N", b, 8'hA1);
    recv_byte(b, 1'b1); chk(b == 8'hA2, "R4 data N+1", b, 8'hA2);
    recv_byte(b, 1'b0); chk(b == 8'hA3, "R4 data N+2", b, 8'hA3);
    chk(sda_oe == 1'b0, "R5 released after nack", sda_oe, 0);
    recv_byte(b, 1'b0); chk(b == 8'hFF, "R5 silent after nack", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    bit a;
    bus_start();
    send_byte(8'hD0, a); chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R1 ignored byte nack", a, 0);
    send_byte(8'h01, a);
    send_byte(8'h77, a); chk(!a, "R1 ignored data nack", a, 0);
    bus_stop();
    chk(rg(0) == 8'h00, "R1 reg0 untouched", rg(0), 0);
  endtask

  task automatic t_abort();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    send_byte(8'h5A, a);
    bit_w(1'b1); bit_w(1'b1); bit_w(1'b0); bit_w(1'b0);
    bus_stop();
    chk(rg(0) == 8'h5A, "R6 byte before stop", rg(0), 8'h5A);
    chk(rg(1) == 8'h00, "R6 partial byte dropped", rg(1), 0);
    bus_start();
    send_byte(8'hDC, a); chk(a, "R6 restart address ack", a, 1);
    send_byte(8'h00, a);
    bus_start();
    send_byte(8'hDD, a);
    recv_byte(b, 1'b1);
    recv_byte(b, 1'b0); chk(b == 8'h5A, "R6 fresh read", b, 8'h5A);
    bus_stop();
  endtask

  task automatic t_count_reg();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'(NREGS), a);
    send_byte(8'h02, a);
    send_byte(8'h03, a); chk(a, "R7 count reg write ack", a, 1);
    send_byte(8'h99, a); chk(a, "R7 beyond bank ack", a, 1);
    bus_stop();
    chk(cnt_o == 8'h03, "R7 count reg written", cnt_o, 3);
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'h06, a);
    bus_start();
    send_byte(8'hDD, a);
    recv_byte(b, 1'b1); chk(b == 8'h03, "R7 new count first", b, 3);
    recv_byte(b, 1'b1); chk(b == 8'h55, "R7 reg6", b, 8'h55);
    recv_byte(b, 1'b1); chk(b == 8'h00, "R7 reg7", b, 0);
    recv_byte(b, 1'b1); chk(b == 8'h03, "R7 count at its index", b, 3);
    recv_byte(b, 1'b0); chk(b == 8'h00, "R7 beyond reads zero", b, 0);
    bus_stop();
  endtask

  initial begin
    #21 rst_n = 1'b1;
    #100;
    t_reset();
    t_block_write();
    t_overrun();
    t_block_read();
    t_bad_addr();
    t_abort();
    t_count_reg();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule